// File: doc/BRIEF.md
# Interrupt-Capable Fetch-Execute Sequencer

This block is the control sequencer of a minimal processor. It owns the program counter and the instruction register. It steps through three phases for each instruction: it fetches a word from a single-ported, word-addressed synchronous memory, hands the instruction to an external execute stub, and then checks for an interrupt. The execute stub is the part that decodes the instruction. When it raises `exec_ack`, it also reports whether the instruction halts the machine, raises a trap (with a handler number), enables interrupts or drops to user mode.

After execution the sequencer advances the PC by one instruction. If an interrupt is pending and interrupts are enabled, the sequencer clears the enable. It then stores the advanced PC into memory word 0 and loads the new PC from memory word 1. A trap skips the advance: it forces supervisor mode and loads the PC from the vector table entry at `TRAP_BASE + n`. The next fetch always uses the PC that was just loaded.

Top module: `fes_top`

## Requirements
- R1: While reset is held, the PC equals `START_ADDR` (16 by default). Interrupts are disabled, the mode is supervisor (`mode_sup`=1), `halted`=0, `exec_go`=0 and `mem_we`=0. After reset, the first instruction executed is the word at `START_ADDR`.
- R2: Without stalls, interrupts or traps, instructions execute at consecutive addresses. A new `exec_go` phase begins every 3 clock cycles (one address cycle, one data cycle, one execute cycle).
- R3: While `exec_go`=1 and `exec_ack`=0, `pc_o` and `ir_o` hold their values and no other phase starts.
- R4: An interrupt request is ignored while the enable is clear. Execution stays sequential and memory is not written.
- R5: When an instruction completes with `irq_req`=1 and the enable set, the sequencer clears the enable. It writes the advanced PC (address of the completed instruction + 1) to memory word 0 with `mem_we`=1. It then reads memory word 1, and that value is the next PC. The write to word 0 is the only memory write the block ever issues.
- R6: `ien_set` sampled with `exec_ack` sets the enable. The new value first applies to the interrupt check of the following instruction, not to the check of the instruction that set it.
- R7: `trap_req` with `trap_num`=n (1..15) sampled with `exec_ack` sets supervisor mode and loads the PC from memory word `TRAP_BASE`+n (1000+n by default). No PC advance happens, and no interrupt is taken after that instruction.
- R8: A trap with number 0 is treated as an illegal instruction and vectors through word `TRAP_BASE` (1000).
- R9: `halt_req` sampled with `exec_ack` stops the machine: `halted` becomes 1, `exec_go` never rises again and the PC keeps the address of the halting instruction. Halt takes priority over a trap reported in the same cycle.
- R10: `user_set` sampled with `exec_ack` clears `mode_sup` (user mode). A later trap returns the mode to supervisor.
- R11: After an interrupt or trap vector load, the very next memory read address is the loaded vector value. No fetch is issued from the old PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | AW (11) | Memory word address |
| mem_rdata | input | DW (16) | Read data, valid one cycle after the address |
| mem_wdata | output | DW (16) | Write data (saved PC, zero-extended) |
| mem_we | output | 1 | Memory write enable |
| pc_o | output | AW (11) | Program counter |
| ir_o | output | DW (16) | Instruction register |
| exec_go | output | 1 | Execute phase active; IR is valid for the stub |
| exec_ack | input | 1 | Stub has finished executing the instruction |
| halt_req | input | 1 | Instruction halts the machine (sampled with exec_ack) |
| trap_req | input | 1 | Instruction is a trap (sampled with exec_ack) |
| trap_num | input | TW (4) | Trap handler number |
| ien_set | input | 1 | Instruction enables interrupts (sampled with exec_ack) |
| user_set | input | 1 | Instruction switches to user mode (sampled with exec_ack) |
| irq_req | input | 1 | Interrupt request line |
| ien | output | 1 | Interrupt enable bit |
| mode_sup | output | 1 | 1 = supervisor mode, 0 = user mode |
| halted | output | 1 | Machine has halted |

## Verification
The hardest case to reach is an interrupt that is pending at the exact completion of the instruction right after the one that enabled interrupts. A trap that completes while an interrupt is pending and enabled is equally hard. Both depend on the interrupt line lining up with a particular execute handshake. The bench therefore uses a stub that decodes the IR the block itself presents, so halt, trap, enable and user strobes arrive with the right `exec_ack` by construction. It can also raise `irq_req` only while a chosen PC is executing. This places the request on one chosen instruction boundary, and the recorded sequence of executed addresses then shows whether, and where, control was diverted.

// File: rtl/fes_pkg.sv
package fes_pkg;

  // Sequencer phases. FADDR presents the fetch address, FDATA captures the
  // word, EXEC runs the handshake, SAVE writes the return PC, VADDR/VDATA
  // read a vector word, HALT is terminal.
  typedef enum logic [2:0] {
    S_FADDR = 3'd0,
    S_FDATA = 3'd1,
    S_EXEC  = 3'd2,
    S_SAVE  = 3'd3,
    S_VADDR = 3'd4,
    S_VDATA = 3'd5,
    S_HALT  = 3'd6
  } seq_state_e;

  // Events decided at the end of an execute phase.
  typedef struct packed {
    logic done;     // execute handshake completed
    logic halt;     // halt accepted
    logic trap;     // trap accepted
    logic irq;      // interrupt accepted
    logic advance;  // PC steps to the next instruction
    logic vec_load; // PC loaded from a vector word
  } seq_ev_t;

endpackage

// File: rtl/fes_fsm.sv
module fes_fsm
  import fes_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec_ack,
  input  logic       halt_req,
  input  logic       trap_req,
  input  logic       irq_req,
  input  logic       ien,
  output seq_state_e state,
  output seq_ev_t    ev,
  output logic       exec_go,
  output logic       halted
);

  seq_state_e state_q, state_d;

  // Named event wires, kept separate so that assertions can watch them.
  logic ev_done, ev_halt, ev_trap, ev_irq;
  assign ev_done = (state_q == S_EXEC) && exec_ack;
  assign ev_halt = ev_done && halt_req;
  assign ev_trap = ev_done && !halt_req && trap_req;
  assign ev_irq  = ev_done && !halt_req && !trap_req && irq_req && ien;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_FADDR: state_d = S_FDATA;
      S_FDATA: state_d = S_EXEC;
      S_EXEC: begin
        if (exec_ack) begin
          if (halt_req)      state_d = S_HALT;
          else if (trap_req) state_d = S_VADDR;
          else if (irq_req && ien) state_d = S_SAVE;
          else               state_d = S_FADDR;
        end
      end
      S_SAVE:  state_d = S_VADDR;
      S_VADDR: state_d = S_VDATA;
      S_VDATA: state_d = S_FADDR;
      S_HALT:  state_d = S_HALT;
      default: state_d = S_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_FADDR;
    else        state_q <= state_d;
  end

  assign state       = state_q;
  assign exec_go     = (state_q == S_EXEC);
  assign halted      = (state_q == S_HALT);
  assign ev.done     = ev_done;
  assign ev.halt     = ev_halt;
  assign ev.trap     = ev_trap;
  assign ev.irq      = ev_irq;
  assign ev.advance  = ev_done && !halt_req && !trap_req;
  assign ev.vec_load = (state_q == S_VDATA);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !exec_go));

  // R3
  stall_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_go && !exec_ack) |=> exec_go);

  // R2
  fetch_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FADDR) |=> ##1 exec_go);

endmodule

// File: rtl/fes_regs.sv
module fes_regs
  import fes_pkg::*;
#(
  parameter int AW         = 11,
  parameter int DW         = 16,
  parameter int TW         = 4,
  parameter int START_ADDR = 16,
  parameter int INSN_STEP  = 1,
  parameter int TRAP_BASE  = 1000,
  parameter int IRQ_VEC    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state,
  input  seq_ev_t       ev,
  input  logic          exec_go,
  input  logic          exec_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic [TW-1:0] trap_num,
  input  logic          ien_set,
  input  logic          user_set,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] vec_addr,
  output logic          ien,
  output logic          mode_sup
);

  // Arithmetic kept in functions so the rule is stated once.
  function automatic logic [AW-1:0] next_pc(input logic [AW-1:0] cur);
    return cur + AW'(INSN_STEP);
  endfunction

  // Number 0 lands on the base entry (illegal-instruction vector).
  function automatic logic [AW-1:0] trap_vector(input logic [TW-1:0] n);
    return AW'(TRAP_BASE) + AW'(n);
  endfunction

  logic [AW-1:0] pc_q, vec_q;
  logic [DW-1:0] ir_q;
  logic          ien_q, sup_q;
  logic          pc_load_ev;

  assign pc_load_ev = ev.advance || ev.vec_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= AW'(START_ADDR);
      ir_q  <= '0;
      vec_q <= '0;
      ien_q <= 1'b0;
      sup_q <= 1'b1;
    end else begin
      if (ev.vec_load)      pc_q <= mem_rdata[AW-1:0];
      else if (ev.advance)  pc_q <= next_pc(pc_q);

      if (state == S_FDATA) ir_q <= mem_rdata;

      if (ev.trap)          vec_q <= trap_vector(trap_num);
      else if (ev.irq)      vec_q <= AW'(IRQ_VEC);

      // Taking an interrupt clears the enable; that wins over a set.
      if (ev.irq)                    ien_q <= 1'b0;
      else if (ev.done && ien_set)   ien_q <= 1'b1;

      if (ev.trap)                   sup_q <= 1'b1;
      else if (ev.done && user_set)  sup_q <= 1'b0;
    end
  end

  assign pc       = pc_q;
  assign ir       = ir_q;
  assign vec_addr = vec_q;
  assign ien      = ien_q;
  assign mode_sup = sup_q;

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_go && !exec_ack) |=> ($stable(ir_q) && $stable(pc_q)));

  // R5
  ien_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.irq |=> !ien_q);

  // R7
  trap_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.trap |=> sup_q);

  // R9
  pc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load_ev |=> $stable(pc_q));

endmodule

// File: rtl/fes_memif.sv
module fes_memif
  import fes_pkg::*;
#(
  parameter int AW       = 11,
  parameter int DW       = 16,
  parameter int IRQ_SAVE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] vec_addr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we
);

  localparam int PAD = DW - AW;

  always_comb begin
    mem_addr = pc;
    mem_we   = 1'b0;
    unique case (state)
      S_SAVE: begin
        mem_addr = AW'(IRQ_SAVE);
        mem_we   = 1'b1;
      end
      S_VADDR: mem_addr = vec_addr;
      default: mem_addr = pc;
    endcase
  end

  // Saved PC is zero-extended to the memory word (requires DW > AW).
  assign mem_wdata = {{PAD{1'b0}}, pc};

  // R5
  save_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == AW'(IRQ_SAVE)));

endmodule

// File: rtl/fes_top.sv
module fes_top
  import fes_pkg::*;
#(
  parameter int AW         = 11,
  parameter int DW         = 16,
  parameter int TW         = 4,
  parameter int START_ADDR = 16,
  parameter int INSN_STEP  = 1,
  parameter int TRAP_BASE  = 1000,
  parameter int IRQ_SAVE   = 0,
  parameter int IRQ_VEC    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ir_o,
  output logic          exec_go,
  input  logic          exec_ack,
  input  logic          halt_req,
  input  logic          trap_req,
  input  logic [TW-1:0] trap_num,
  input  logic          ien_set,
  input  logic          user_set,
  input  logic          irq_req,
  output logic          ien,
  output logic          mode_sup,
  output logic          halted
);

  seq_state_e    state;
  seq_ev_t       ev;
  logic [AW-1:0] vec_addr;

  fes_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_ack (exec_ack),
    .halt_req (halt_req),
    .trap_req (trap_req),
    .irq_req  (irq_req),
    .ien      (ien),
    .state    (state),
    .ev       (ev),
    .exec_go  (exec_go),
    .halted   (halted)
  );

  fes_regs #(
    .AW(AW), .DW(DW), .TW(TW), .START_ADDR(START_ADDR),
    .INSN_STEP(INSN_STEP), .TRAP_BASE(TRAP_BASE), .IRQ_VEC(IRQ_VEC)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .ev        (ev),
    .exec_go   (exec_go),
    .exec_ack  (exec_ack),
    .mem_rdata (mem_rdata),
    .trap_num  (trap_num),
    .ien_set   (ien_set),
    .user_set  (user_set),
    .pc        (pc_o),
    .ir        (ir_o),
    .vec_addr  (vec_addr),
    .ien       (ien),
    .mode_sup  (mode_sup)
  );

  fes_memif #(.AW(AW), .DW(DW), .IRQ_SAVE(IRQ_SAVE)) u_memif (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .pc        (pc_o),
    .vec_addr  (vec_addr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  // R5
  irq_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.irq |=> (mem_we && mem_wdata[AW-1:0] == pc_o));

  // R11
  vec_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.vec_load |=> (mem_addr == $past(mem_rdata[AW-1:0])));

  // R4
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.done && !ien) |=> !mem_we);

endmodule

// File: tb/fes_top_bench.sv
module fes_top_bench;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int TW = 4;
  // Stub instruction words
  localparam logic [DW-1:0] NOP  = 16'h0000;
  localparam logic [DW-1:0] HLT  = 16'hF000;
  localparam logic [DW-1:0] HLTT = 16'hF803; // halt and trap 3 together
  localparam logic [DW-1:0] EI   = 16'hE000;
  localparam logic [DW-1:0] USR  = 16'hD000;
  localparam logic [DW-1:0] TRP  = 16'hC000; // low nibble = trap number

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [AW-1:0] mem_addr, pc_o;
  logic [DW-1:0] mem_rdata, mem_wdata, ir_o;
  logic mem_we, exec_go, exec_ack, halt_req, trap_req, ien_set, user_set;
  logic irq_req, ien, mode_sup, halted;
  logic [TW-1:0] trap_num;

  // Memory model with a bench-side load port
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  always @(posedge clk) begin
    if (mem_we)     mem[mem_addr] <= mem_wdata;
    else if (ld_en) mem[ld_addr]  <= ld_data;
    mem_rdata <= mem[mem_addr];
  end

  // Execute stub decoding the presented IR
  int            ack_delay = 0;
  int            wait_cnt;
  logic          irq_line = 1'b0;
  int            irq_at = -1;
  always @(posedge clk) wait_cnt <= (exec_go && !exec_ack) ? wait_cnt + 1 : 0;
  assign exec_ack = exec_go && (wait_cnt >= ack_delay);
  assign halt_req = (ir_o[15:12] == 4'hF);
  assign trap_req = (ir_o[15:12] == 4'hC) || (ir_o[15:12] == 4'hF && ir_o[11]);
  assign trap_num = ir_o[3:0];
  assign ien_set  = (ir_o[15:12] == 4'hE);
  assign user_set = (ir_o[15:12] == 4'hD);
  assign irq_req  = irq_line || (exec_go && int'(pc_o) == irq_at);

  fes_top u_fes_top (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .pc_o(pc_o), .ir_o(ir_o),
    .exec_go(exec_go), .exec_ack(exec_ack), .halt_req(halt_req),
    .trap_req(trap_req), .trap_num(trap_num), .ien_set(ien_set),
    .user_set(user_set), .irq_req(irq_req), .ien(ien),
    .mode_sup(mode_sup), .halted(halted)
  );

  // Trace of completed executes
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  logic tr_clr = 1'b1;
  int tr_n;
  int tr_pc [0:15];
  int tr_cyc [0:15];
  logic tr_mode [0:15];
  always @(negedge clk) begin
    if (tr_clr) tr_n <= 0;
    else if (exec_go && exec_ack && tr_n < 16) begin
      tr_pc[tr_n]   <= int'(pc_o);
      tr_cyc[tr_n]  <= cyc;
      tr_mode[tr_n] <= mode_sup;
      tr_n          <= tr_n + 1;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0; tr_clr = 1'b1; irq_line = 1'b0; irq_at = -1; ack_delay = 0;
  endtask

  task automatic run();
    @(negedge clk);
    tr_clr = 1'b0; rst_n = 1'b1;
    for (int i = 0; i < 300 && !halted; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    enter_reset();
    poke(16, HLT);
    @(negedge clk);
    check(int'(pc_o) == 16, "R1 pc", int'(pc_o), 16);
    check(!ien && mode_sup && !halted && !exec_go && !mem_we, "R1 flags",
          {ien, mode_sup, halted, exec_go, mem_we}, 5'b01000);
  endtask

  task automatic t_seq();
    enter_reset();
    poke(16, NOP); poke(17, NOP); poke(18, NOP); poke(19, HLT);
    run();
    check(tr_n == 4, "R2 count", tr_n, 4);
    check(tr_pc[0] == 16 && tr_pc[3] == 19, "R1 R2 order", tr_pc[3], 19);
    check(tr_cyc[1] - tr_cyc[0] == 3 && tr_cyc[2] - tr_cyc[1] == 3, "R2 spacing",
          tr_cyc[2] - tr_cyc[1], 3);
    repeat (10) @(negedge clk);
    check(halted && tr_n == 4 && int'(pc_o) == 19 && !exec_go, "R9 hold",
          int'(pc_o), 19);
  endtask

  task automatic t_stall();
    logic [AW-1:0] p0;
    logic [DW-1:0] i0;
    enter_reset();
    poke(16, NOP); poke(17, USR); poke(18, HLT);
    ack_delay = 2;
    @(negedge clk); tr_clr = 1'b0; rst_n = 1'b1;
    while (!(exec_go && !exec_ack)) @(negedge clk);
    p0 = pc_o; i0 = ir_o;
    @(negedge clk);
    check(exec_go && pc_o == p0 && ir_o == i0, "R3 hold", int'(pc_o), int'(p0));
    for (int i = 0; i < 300 && !halted; i++) @(negedge clk);
    check(tr_n == 3 && tr_cyc[1] - tr_cyc[0] == 5, "R3 spacing",
          tr_cyc[1] - tr_cyc[0], 5);
    check(!mode_sup, "R10 user", mode_sup, 0);
  endtask

  task automatic t_masked();
    enter_reset();
    poke(0, 16'hAAAA);
    poke(16, NOP); poke(17, NOP); poke(18, HLT);
    irq_line = 1'b1;
    run();
    check(tr_n == 3 && tr_pc[1] == 17 && tr_pc[2] == 18, "R4 sequential", tr_pc[2], 18);
    check(mem[0] == 16'hAAAA, "R4 no write", int'(mem[0]), 16'hAAAA);
  endtask

  task automatic t_irq();
    enter_reset();
    poke(1, 16'd300); poke(300, HLT);
    poke(16, EI); poke(17, NOP); poke(18, HLT);
    irq_line = 1'b1;
    run();
    check(tr_n == 3 && tr_pc[1] == 17, "R6 not same instruction", tr_pc[1], 17);
    check(tr_pc[2] == 300, "R5 R11 vector", tr_pc[2], 300);
    check(mem[0] == 16'd18, "R5 saved pc", int'(mem[0]), 18);
    check(!ien, "R5 ien cleared", ien, 0);
    check(tr_cyc[2] - tr_cyc[1] == 6, "R5 entry cycles", tr_cyc[2] - tr_cyc[1], 6);
  endtask

  task automatic t_trap();
    enter_reset();
    poke(1005, 16'd400); poke(400, NOP); poke(401, HLT);
    poke(16, USR); poke(17, TRP | 16'h5);
    run();
    check(tr_n == 4 && tr_pc[2] == 400 && tr_pc[3] == 401, "R7 vector", tr_pc[2], 400);
    check(tr_mode[1] == 1'b0 && tr_mode[2] == 1'b1, "R10 R7 mode", tr_mode[2], 1);
  endtask

  task automatic t_trap_irq();
    enter_reset();
    poke(0, 16'h5555); poke(1, 16'd700); poke(700, HLT);
    poke(1003, 16'd500); poke(500, NOP); poke(501, HLT);
    poke(16, EI); poke(17, TRP | 16'h3);
    irq_at = 17;
    run();
    check(tr_n == 4 && tr_pc[2] == 500, "R7 trap over irq", tr_pc[2], 500);
    check(mem[0] == 16'h5555 && ien, "R7 no irq entry", int'(mem[0]), 16'h5555);
  endtask

  task automatic t_trap0();
    enter_reset();
    poke(1000, 16'd600); poke(600, HLT);
    poke(16, TRP);
    run();
    check(tr_n == 2 && tr_pc[1] == 600, "R8 illegal vector", tr_pc[1], 600);
  endtask

  task automatic t_halt_trap();
    enter_reset();
    poke(1003, 16'd500);
    poke(16, HLTT);
    run();
    repeat (6) @(negedge clk);
    check(halted && tr_n == 1 && int'(pc_o) == 16, "R9 halt priority", int'(pc_o), 16);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_seq();
    t_stall();
    t_masked();
    t_irq();
    t_trap();
    t_trap_irq();
    t_trap0();
    t_halt_trap();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule